// File: doc/BRIEF.md
# Ping-Pong Tile Pipeline Controller

This controller walks a runtime number of tiles through a load, compute and store pipeline built on two pairs of alternating buffers. It issues one-cycle start pulses to three external engines (a loader that fills an input buffer, a compute engine that turns an input buffer into an output buffer, and a storer that drains an output buffer to memory). Each engine answers with a one-cycle done pulse. Every start carries the tile index and a buffer select that names which member of the pair to use.

Loading the next tile and storing the previous result run during the same step as computing the current tile. A step ends only when every engine started in that step has reported done. A single load fills the first buffer before the main steps begin, and a single store drains the last result after them. The cost is four buffers, where a non-overlapped design needs two half as many. With one tile the controller degenerates to load, compute, store in strict series.

Top module: `pingpong_tile_ctrl`

## Requirements
- R1: After reset, busy, done and all three start outputs are 0.
- R2: A start pulse while idle with a non-zero tile count N raises busy on the next cycle. In that same cycle the controller issues a load of tile 0 into buffer select 0 (0 means ping, 1 means pong), with no compute or store start.
- R3: In step i (0 to N-1) a compute start carries tile i with select equal to bit 0 of i, for both the input and the output buffer.
- R4: A load of tile i+1, with select equal to bit 0 of i+1, is issued in the same cycle as the compute start of step i, and only when i < N-1.
- R5: A store of tile i-1, with select equal to bit 0 of i-1, is issued in the same cycle as the compute start of step i, and only when i > 0.
- R6: After the last step completes, one store of tile N-1 with select equal to bit 0 of N-1 is issued alone.
- R7: A new step, or the final store, begins only after the done of every engine started in the previous step. Every start is a one-cycle pulse.
- R8: With N = 1 the order is load, compute, store, each starting only after the previous one's done.
- R9: busy stays high until the cycle in which the final store's done is sampled. done is then a one-cycle pulse in the cycle after, with busy low.
- R10: A start pulse while busy, or with N = 0 while idle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (pulse) |
| tile_count | input | CNT_W | Number of tiles N for the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_start | output | 1 | Load engine start pulse |
| rd_sel | output | 1 | Input buffer to fill (0 ping, 1 pong) |
| rd_tile | output | CNT_W | Tile index to load |
| rd_done | input | 1 | Load engine done pulse |
| ex_start | output | 1 | Compute engine start pulse |
| ex_sel | output | 1 | Input/output buffer pair to use |
| ex_tile | output | CNT_W | Tile index computed |
| ex_done | input | 1 | Compute engine done pulse |
| wr_start | output | 1 | Store engine start pulse |
| wr_sel | output | 1 | Output buffer to drain |
| wr_tile | output | CNT_W | Tile index stored |
| wr_done | input | 1 | Store engine done pulse |

## Verification
The assertions take for granted that each engine raises its done exactly once per start, for a single cycle, and never in the same cycle as that start. A done that arrives without an outstanding start would otherwise be treated as undefined input. The bench engine models keep to this: each one logs a start, waits a random one to six cycles, and pulses done once. Run lengths are random, and directed runs cover one, two and three tiles, a zero count and a restart attempt mid-run. The tile count never exceeds what the bench logs hold.

// File: rtl/pp_tile_pkg.sv
package pp_tile_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRO_ISSUE,
        ST_PRO_WAIT,
        ST_IT_ISSUE,
        ST_IT_WAIT,
        ST_EPI_ISSUE,
        ST_EPI_WAIT
    } seq_state_e;

    typedef enum logic {
        BUF_PING = 1'b0,
        BUF_PONG = 1'b1
    } buf_sel_e;

    localparam int NUM_ENG = 3;
    localparam int ENG_RD  = 0;
    localparam int ENG_EX  = 1;
    localparam int ENG_WR  = 2;

    // buffer of a given parity
    function automatic buf_sel_e parity_buf(input logic lsb);
        return lsb ? BUF_PONG : BUF_PING;
    endfunction

    // buffer of the opposite parity
    function automatic buf_sel_e other_buf(input logic lsb);
        return lsb ? BUF_PING : BUF_PONG;
    endfunction

endpackage

// File: rtl/pp_seq_fsm.sv
module pp_seq_fsm
    import pp_tile_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] tile_count,
    input  logic             all_clear,
    output seq_state_e       state,
    output logic [CNT_W-1:0] iter,
    output logic [CNT_W-1:0] last_idx,
    output logic             busy,
    output logic             done
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] iter_q;
    logic [CNT_W-1:0] last_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && (tile_count != '0)) begin
                        last_q  <= tile_count - CNT_W'(1);
                        iter_q  <= '0;
                        state_q <= ST_PRO_ISSUE;
                    end
                end
                ST_PRO_ISSUE: state_q <= ST_PRO_WAIT;
                ST_PRO_WAIT: begin
                    if (all_clear) state_q <= ST_IT_ISSUE;
                end
                ST_IT_ISSUE: state_q <= ST_IT_WAIT;
                ST_IT_WAIT: begin
                    if (all_clear) begin
                        if (iter_q == last_q) begin
                            state_q <= ST_EPI_ISSUE;
                        end else begin
                            iter_q  <= iter_q + CNT_W'(1);
                            state_q <= ST_IT_ISSUE;
                        end
                    end
                end
                ST_EPI_ISSUE: state_q <= ST_EPI_WAIT;
                ST_EPI_WAIT: begin
                    if (all_clear) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state    = state_q;
    assign iter     = iter_q;
    assign last_idx = last_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;

endmodule

// File: rtl/pp_cmd_gen.sv
module pp_cmd_gen
    import pp_tile_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  seq_state_e         state,
    input  logic [CNT_W-1:0]   iter,
    input  logic [CNT_W-1:0]   last_idx,
    output logic [NUM_ENG-1:0] issue,
    output logic               rd_sel,
    output logic [CNT_W-1:0]   rd_tile,
    output logic               ex_sel,
    output logic [CNT_W-1:0]   ex_tile,
    output logic               wr_sel,
    output logic [CNT_W-1:0]   wr_tile
);

    logic in_step;
    logic has_next;
    logic has_prev;

    always_comb begin
        in_step  = (state == ST_IT_ISSUE);
        has_next = (iter != last_idx);
        has_prev = (iter != '0);

        issue          = '0;
        issue[ENG_RD]  = (state == ST_PRO_ISSUE) || (in_step && has_next);
        issue[ENG_EX]  = in_step;
        issue[ENG_WR]  = (state == ST_EPI_ISSUE) || (in_step && has_prev);

        // load: prologue fills ping with tile 0, steps prefetch the idle buffer
        if (state == ST_PRO_ISSUE) begin
            rd_tile = '0;
            rd_sel  = BUF_PING;
        end else begin
            rd_tile = iter + CNT_W'(1);
            rd_sel  = other_buf(iter[0]);
        end

        ex_tile = iter;
        ex_sel  = parity_buf(iter[0]);

        // store: steps drain the buffer compute is not filling, epilogue drains the last
        if (state == ST_EPI_ISSUE) begin
            wr_tile = last_idx;
            wr_sel  = parity_buf(last_idx[0]);
        end else begin
            wr_tile = iter - CNT_W'(1);
            wr_sel  = other_buf(iter[0]);
        end
    end

endmodule

// File: rtl/pp_pend_tracker.sv
module pp_pend_tracker #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] issue,
    input  logic [NUM-1:0] done_in,
    output logic           all_clear
);

    logic [NUM-1:0] pend_q;
    logic [NUM-1:0] still_open;

    for (genvar e = 0; e < NUM; e++) begin : g_eng
        always_ff @(posedge clk) begin
            if (rst)           pend_q[e] <= 1'b0;
            else if (issue[e]) pend_q[e] <= 1'b1;
            else if (done_in[e]) pend_q[e] <= 1'b0;
        end
        assign still_open[e] = pend_q[e] & ~done_in[e];
    end

    assign all_clear = (still_open == '0);

endmodule

// File: rtl/pingpong_tile_ctrl.sv
module pingpong_tile_ctrl
    import pp_tile_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] tile_count,
    output logic             busy,
    output logic             done,
    output logic             rd_start,
    output logic             rd_sel,
    output logic [CNT_W-1:0] rd_tile,
    input  logic             rd_done,
    output logic             ex_start,
    output logic             ex_sel,
    output logic [CNT_W-1:0] ex_tile,
    input  logic             ex_done,
    output logic             wr_start,
    output logic             wr_sel,
    output logic [CNT_W-1:0] wr_tile,
    input  logic             wr_done
);

    seq_state_e         state;
    logic [CNT_W-1:0]   iter;
    logic [CNT_W-1:0]   last_idx;
    logic               all_clear;
    logic [NUM_ENG-1:0] issue;
    logic [NUM_ENG-1:0] eng_done;

    assign eng_done[ENG_RD] = rd_done;
    assign eng_done[ENG_EX] = ex_done;
    assign eng_done[ENG_WR] = wr_done;

    pp_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tile_count (tile_count),
        .all_clear  (all_clear),
        .state      (state),
        .iter       (iter),
        .last_idx   (last_idx),
        .busy       (busy),
        .done       (done)
    );

    pp_cmd_gen #(.CNT_W(CNT_W)) u_cmd (
        .state    (state),
        .iter     (iter),
        .last_idx (last_idx),
        .issue    (issue),
        .rd_sel   (rd_sel),
        .rd_tile  (rd_tile),
        .ex_sel   (ex_sel),
        .ex_tile  (ex_tile),
        .wr_sel   (wr_sel),
        .wr_tile  (wr_tile)
    );

    pp_pend_tracker #(.NUM(NUM_ENG)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .done_in   (eng_done),
        .all_clear (all_clear)
    );

    assign rd_start = issue[ENG_RD];
    assign ex_start = issue[ENG_EX];
    assign wr_start = issue[ENG_WR];

endmodule

// File: rtl/pp_tile_ctrl_chk.sv
module pp_tile_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             rd_start,
    input logic             rd_sel,
    input logic [CNT_W-1:0] rd_tile,
    input logic             ex_start,
    input logic             ex_sel,
    input logic [CNT_W-1:0] ex_tile,
    input logic             wr_start,
    input logic             wr_sel,
    input logic [CNT_W-1:0] wr_tile
);

    a_r3_ex_sel_parity: assert property (@(posedge clk) disable iff (rst)
        ex_start |-> (ex_sel == ex_tile[0]));

    a_r4_rd_sel_parity: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> (rd_sel == rd_tile[0]));

    a_r5_wr_sel_parity: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> (wr_sel == wr_tile[0]));

    a_r4_prefetch_with_ex: assert property (@(posedge clk) disable iff (rst)
        (rd_start && (rd_tile != '0)) |-> (ex_start && (ex_tile == rd_tile - CNT_W'(1))));

    a_r5_drain_with_ex: assert property (@(posedge clk) disable iff (rst)
        (wr_start && ex_start) |-> (ex_tile == wr_tile + CNT_W'(1)));

    a_r2_prologue_alone: assert property (@(posedge clk) disable iff (rst)
        (rd_start && (rd_tile == '0)) |-> (!ex_start && !wr_start));

    a_r6_epilogue_alone: assert property (@(posedge clk) disable iff (rst)
        (wr_start && !ex_start) |-> !rd_start);

    a_r7_one_cycle_starts: assert property (@(posedge clk) disable iff (rst)
        (rd_start || ex_start || wr_start) |=> !(rd_start || ex_start || wr_start));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(rd_start || ex_start || wr_start));

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

bind pingpong_tile_ctrl pp_tile_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .rd_start (rd_start),
    .rd_sel   (rd_sel),
    .rd_tile  (rd_tile),
    .ex_start (ex_start),
    .ex_sel   (ex_sel),
    .ex_tile  (ex_tile),
    .wr_start (wr_start),
    .wr_sel   (wr_sel),
    .wr_tile  (wr_tile)
);

// File: tb/test_pingpong_tile_ctrl.sv
`timescale 1ns/1ps
module test_pingpong_tile_ctrl;

    localparam int CNT_W = 8;
    localparam int LOGN  = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] tile_count = '0;
    logic             busy, done;
    logic             rd_start, rd_sel, ex_start, ex_sel, wr_start, wr_sel;
    logic [CNT_W-1:0] rd_tile, ex_tile, wr_tile;
    logic             rd_done = 1'b0, ex_done = 1'b0, wr_done = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int rd_n, ex_n, wr_n;
    int rd_t [LOGN], ex_t [LOGN], wr_t [LOGN];
    int rd_s [LOGN], ex_s [LOGN], wr_s [LOGN];
    int rd_sc[LOGN], ex_sc[LOGN], wr_sc[LOGN];
    int rd_dc[LOGN], ex_dc[LOGN], wr_dc[LOGN];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pingpong_tile_ctrl #(.CNT_W(CNT_W)) i_pingpong_tile_ctrl (
        .clk(clk), .rst(rst), .start(start), .tile_count(tile_count),
        .busy(busy), .done(done),
        .rd_start(rd_start), .rd_sel(rd_sel), .rd_tile(rd_tile), .rd_done(rd_done),
        .ex_start(ex_start), .ex_sel(ex_sel), .ex_tile(ex_tile), .ex_done(ex_done),
        .wr_start(wr_start), .wr_sel(wr_sel), .wr_tile(wr_tile), .wr_done(wr_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // engine models: log start, wait 1..6 cycles, pulse done once
    initial begin : eng_rd
        forever begin
            @(negedge clk);
            rd_done = 1'b0;
            if (rd_start && rd_n < LOGN) begin
                automatic int lat = 1 + int'($urandom_range(0, 5));
                rd_t[rd_n] = int'(rd_tile); rd_s[rd_n] = int'(rd_sel); rd_sc[rd_n] = cyc;
                repeat (lat) @(negedge clk);
                rd_done = 1'b1; rd_dc[rd_n] = cyc; rd_n++;
            end
        end
    end

    initial begin : eng_ex
        forever begin
            @(negedge clk);
            ex_done = 1'b0;
            if (ex_start && ex_n < LOGN) begin
                automatic int lat = 1 + int'($urandom_range(0, 5));
                ex_t[ex_n] = int'(ex_tile); ex_s[ex_n] = int'(ex_sel); ex_sc[ex_n] = cyc;
                repeat (lat) @(negedge clk);
                ex_done = 1'b1; ex_dc[ex_n] = cyc; ex_n++;
            end
        end
    end

    initial begin : eng_wr
        forever begin
            @(negedge clk);
            wr_done = 1'b0;
            if (wr_start && wr_n < LOGN) begin
                automatic int lat = 1 + int'($urandom_range(0, 5));
                wr_t[wr_n] = int'(wr_tile); wr_s[wr_n] = int'(wr_sel); wr_sc[wr_n] = cyc;
                repeat (lat) @(negedge clk);
                wr_done = 1'b1; wr_dc[wr_n] = cyc; wr_n++;
            end
        end
    end

    // one run of n tiles; optional restart attempt (R10) a few cycles in
    task automatic run(input int n, input bit poke);
        int s_cyc, d_cyc, w;
        bit early_drop;
        rd_n = 0; ex_n = 0; wr_n = 0;
        @(negedge clk);
        tile_count = CNT_W'(n);
        start = 1'b1;
        s_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(rd_start == 1'b1 && rd_tile == '0 && rd_sel == 1'b0, "R2 prologue load tile0 ping",
            int'(rd_start), 1);
        chk(!ex_start && !wr_start, "R2 prologue alone", int'(ex_start | wr_start), 0);
        early_drop = 1'b0;
        d_cyc = -1;
        for (w = 0; w < 5000; w++) begin
            if (poke && w == 3) begin
                tile_count = CNT_W'(n + 7);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (done) begin
                d_cyc = cyc;
                break;
            end
            if (!busy) early_drop = 1'b1;
        end
        start = 1'b0;
        chk(d_cyc >= 0, "R9 done seen", d_cyc, 0);
        chk(!early_drop, "R9 busy held until final store", int'(early_drop), 0);
        chk(!busy, "R9 busy low with done", int'(busy), 0);
        chk(rd_n == n, "R4 load count", rd_n, n);
        chk(ex_n == n, "R3 compute count", ex_n, n);
        chk(wr_n == n, "R6 store count", wr_n, n);
        if (rd_n == n && ex_n == n && wr_n == n) begin
            chk(rd_sc[0] == s_cyc + 1, "R2 prologue timing", rd_sc[0], s_cyc + 1);
            for (int i = 0; i < n; i++) begin
                chk(rd_t[i] == i && rd_s[i] == (i % 2), "R4 load tile/sel", rd_t[i] * 2 + rd_s[i], i * 2 + i % 2);
                chk(ex_t[i] == i && ex_s[i] == (i % 2), "R3 compute tile/sel", ex_t[i] * 2 + ex_s[i], i * 2 + i % 2);
                chk(wr_t[i] == i && wr_s[i] == (i % 2), "R5 store tile/sel", wr_t[i] * 2 + wr_s[i], i * 2 + i % 2);
                chk(ex_sc[i] > rd_dc[i], "R7 compute after its load", ex_sc[i], rd_dc[i] + 1);
                if (i < n - 1)
                    chk(rd_sc[i + 1] == ex_sc[i], "R4 prefetch overlaps compute", rd_sc[i + 1], ex_sc[i]);
                if (i > 0)
                    chk(wr_sc[i - 1] == ex_sc[i], "R5 drain overlaps compute", wr_sc[i - 1], ex_sc[i]);
                if (i < n - 1) begin
                    automatic int lastd = imax(ex_dc[i], rd_dc[i + 1]);
                    if (i > 0) lastd = imax(lastd, wr_dc[i - 1]);
                    chk(ex_sc[i + 1] > lastd, "R7 step barrier", ex_sc[i + 1], lastd + 1);
                end
            end
            begin
                automatic int lastd = ex_dc[n - 1];
                if (n > 1) lastd = imax(lastd, wr_dc[n - 2]);
                chk(wr_sc[n - 1] > lastd, "R6 final store after last step", wr_sc[n - 1], lastd + 1);
            end
            if (n == 1)
                chk(ex_sc[0] > rd_dc[0] && wr_sc[0] > ex_dc[0], "R8 single tile serial",
                    wr_sc[0], ex_dc[0] + 1);
            chk(d_cyc == wr_dc[n - 1] + 1, "R9 done timing", d_cyc, wr_dc[n - 1] + 1);
        end
        @(negedge clk);
        chk(!done && !busy, "R9 done single pulse", int'(done), 0);
        chk(rd_n == n, "R10 no restart", rd_n, n);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        automatic int seedv = int'($urandom(32'd24681));
        seedv = seedv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1 reset status", int'(busy | done), 0);
        chk(!rd_start && !ex_start && !wr_start, "R1 reset starts", int'(rd_start | ex_start | wr_start), 0);

        // R10: zero count ignored
        rd_n = 0; ex_n = 0; wr_n = 0;
        tile_count = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && rd_n == 0, "R10 zero count ignored", rd_n + int'(busy), 0);

        run(1, 1'b0);   // R8
        run(2, 1'b0);
        run(3, 1'b0);
        run(5, 1'b1);   // R10 restart attempt while busy
        for (int k = 0; k < 6; k++) begin
            run(1 + int'($urandom_range(0, 39)), 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule